// File: doc/BRIEF.md
# Dual-Mode UART Transmit Path

This block is the sending half of an asynchronous serial port. Software hands it bytes through a write-only byte port. A control input selects one of two buffering schemes. In single mode the block keeps one holding byte. In queued mode it keeps a sixteen-entry byte queue. From either buffer, bytes move into a shift register. The shift register sends each byte as a frame: a low start bit, seven or eight data bits, then a high stop bit. Each bit lasts one period of a baud tick supplied from outside. Bit order (least or most significant first) and data length are live control inputs, and software keeps them steady while a frame is on the line.

Two single-cycle interrupt pulses tell software when to act. The space pulse says the buffer can take more data. In single mode it fires for every byte moved. In queued mode it fires once per batch of trigger-level bytes. The drained pulse fires only in queued mode, when the queue and the shift register have both run dry. In queued mode the usual sequence is to fill the queue to at least the trigger level while sending is disabled, then set the enable. A sticky flag records any write that was dropped because the buffer was full. Clearing the enable lets the frame in flight finish and then discards whatever is still queued.

Top module: `dual_tx_path`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits, then one high stop bit. The line changes level only in the cycle after a clock edge at which `baudTick` was high, so each bit lasts one tick period.
- R2: With `sevenBit`=0 and `msbFirst`=0, data bits go out as d0 through d7. With `msbFirst`=1 they go out as d7 down to d0. With `sevenBit`=1 and `msbFirst`=0 they go out as d0 through d6, and d7 never appears. With `sevenBit`=1 and `msbFirst`=1 they go out as d7 down to d1, and d0 never appears.
- R3: In single mode (`fifoMode`=0) the buffer holds one byte. While `txEnable`=1, a held byte moves into an idle shift register at the next baud tick and its frame starts. A write made while a byte is already held is dropped.
- R4: In single mode, `spaceIrq` pulses for one cycle each time the held byte moves into the shift register.
- R5: In queued mode (`fifoMode`=1) the queue holds 16 bytes, sent in write order. No frame starts until `txEnable`=1 and the queue holds at least the trigger count. The trigger count is `trigLevel`, and a value of 0 means 16. Once sending has begun, it continues until the queue and the shift register are both empty.
- R6: In queued mode, `spaceIrq` pulses once for every trigger-count bytes moved out of the queue.
- R7: In queued mode, `emptyIrq` pulses for one cycle when a stop bit ends with the queue empty. It never pulses in single mode.
- R8: A write to a full buffer is dropped and sets `overflow`. Only reset clears `overflow`.
- R9: When `txEnable` falls, the frame on the line completes. Every byte still buffered is then discarded and is never sent.
- R10: After reset, `txLine` is high, both interrupts and `overflow` are low, and the buffer is empty. The storage behind the byte port resets to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoMode | input | 1 | 0 selects the single holding byte, 1 selects the 16-entry queue |
| txEnable | input | 1 | Transmit enable; a falling edge flushes the buffer after the current frame |
| trigLevel | input | 4 | Queued-mode trigger count (0 means 16) |
| msbFirst | input | 1 | 1 sends the most significant bit first |
| sevenBit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| wrValid | input | 1 | Byte write strobe, one byte per cycle |
| wrData | input | 8 | Byte to transmit |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| txLine | output | 1 | Serial output |
| spaceIrq | output | 1 | Buffer-space interrupt pulse |
| emptyIrq | output | 1 | Queue and shifter drained pulse (queued mode) |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A corrupted queue pointer or occupancy count shows up on the line within one frame time. A byte comes out in the wrong order, is repeated, goes missing, or an unexpected frame appears. The frame decoder catches each of these against the bench's model of accepted writes. A bad bit counter or a bad ordering mux breaks the data or the stop bit of the very frame it touches. A wrong batch or arming state shows as a frame that starts too early or never starts, or as a miscount of space and drained pulses. These are checked at the end of each scenario, a few hundred cycles later.

// File: rtl/dual_tx_pkg.sv
package dual_tx_pkg;
  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic push;     // store wrData at the tail
    logic load;     // move head byte into the shifter, begin frame
    logic flush;    // discard every buffered byte
    logic advance;  // bit boundary for the shifter
  } dpStrobe_t;
endpackage

// File: rtl/dual_tx_dp.sv
module dual_tx_dp
  import dual_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [DW-1:0] wrData,
  input  logic          msbFirst,
  input  logic          sevenBit,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          frameDone,
  output logic          txLine
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [DW-1:0] head, revHead, ordered, shiftReg;
  logic [RW-1:0] remain;

  assign head = mem[rdPtr];

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign revHead[i] = head[DW-1-i];
  end

  // Reversal puts the top bit at position 0; in 7-bit mode the dropped
  // bit falls off the end of the shorter count in either order.
  assign ordered = msbFirst ? revHead : head;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '1;
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) begin
        mem[wrPtr] <= wrData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (stb.load) rdPtr <= nextPtr(rdPtr);
      count <= count + {{(CW-1){1'b0}}, stb.push} - {{(CW-1){1'b0}}, stb.load};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      txLine   <= 1'b1;
      shiftReg <= '1;
      remain   <= '0;
    end else if (stb.load) begin
      busy     <= 1'b1;
      txLine   <= 1'b0;
      shiftReg <= ordered;
      remain   <= sevenBit ? RW'(DW) : RW'(DW + 1);
    end else if (stb.advance && busy) begin
      if (remain > RW'(1)) begin
        txLine   <= shiftReg[0];
        shiftReg <= {1'b1, shiftReg[DW-1:1]};
        remain   <= remain - RW'(1);
      end else if (remain == RW'(1)) begin
        txLine <= 1'b1;
        remain <= '0;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign frameDone = busy && (remain == '0);
endmodule

// File: rtl/dual_tx_ctrl.sv
module dual_tx_ctrl
  import dual_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoMode,
  input  logic          txEnable,
  input  logic [TW-1:0] trigLevel,
  input  logic          wrValid,
  input  logic          baudTick,
  input  logic [CW-1:0] count,
  input  logic          busy,
  input  logic          frameDone,
  output dpStrobe_t     stb,
  output logic          spaceIrq,
  output logic          emptyIrq,
  output logic          overflow
);
  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_S = CW'(1);

  logic [CW-1:0] cap, trigEff, batch, batchNext;
  logic enPrev, flushPend, armed;
  logic shifterFree, gateOk, flushNow, drop, emptyEvent, batchHit;

  always_comb begin
    cap         = fifoMode ? CAP_Q : CAP_S;
    trigEff     = (trigLevel == '0) ? CAP_Q : CW'(trigLevel);
    shifterFree = !busy || frameDone;
    gateOk      = txEnable && (!fifoMode || armed || (count >= trigEff));
    flushNow    = flushPend && !busy;

    stb.flush   = flushNow;
    stb.advance = baudTick;
    stb.load    = baudTick && shifterFree && gateOk && (count != '0) && !flushNow;
    stb.push    = wrValid && !flushNow && (count < cap);
    drop        = wrValid && !flushNow && (count >= cap);

    emptyEvent  = fifoMode && baudTick && frameDone && !stb.load && (count == '0);
    batchNext   = batch + CW'(1);
    batchHit    = (batchNext == trigEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev    <= 1'b0;
      flushPend <= 1'b0;
      armed     <= 1'b0;
      batch     <= '0;
      spaceIrq  <= 1'b0;
      emptyIrq  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      enPrev <= txEnable;
      if (enPrev && !txEnable)   flushPend <= 1'b1;
      else if (flushNow)         flushPend <= 1'b0;

      if (flushNow || emptyEvent)       armed <= 1'b0;
      else if (fifoMode && stb.load)    armed <= 1'b1;

      if (flushNow || emptyEvent || !fifoMode) batch <= '0;
      else if (stb.load)                       batch <= batchHit ? '0 : batchNext;

      spaceIrq <= stb.load && (!fifoMode || batchHit);
      emptyIrq <= emptyEvent;
      overflow <= overflow | drop;
    end
  end
endmodule

// File: rtl/dual_tx_path.sv
module dual_tx_path
  import dual_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoMode,
  input  logic          txEnable,
  input  logic [TW-1:0] trigLevel,
  input  logic          msbFirst,
  input  logic          sevenBit,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          baudTick,
  output logic          txLine,
  output logic          spaceIrq,
  output logic          emptyIrq,
  output logic          overflow
);
  dpStrobe_t     stb;
  logic [CW-1:0] qCount;
  logic          busy, frameDone;

  dual_tx_ctrl #(.DEPTH(DEPTH), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .txEnable(txEnable),
    .trigLevel(trigLevel), .wrValid(wrValid), .baudTick(baudTick),
    .count(qCount), .busy(busy), .frameDone(frameDone), .stb(stb),
    .spaceIrq(spaceIrq), .emptyIrq(emptyIrq), .overflow(overflow)
  );

  dual_tx_dp #(.DEPTH(DEPTH), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .msbFirst(msbFirst), .sevenBit(sevenBit), .count(qCount),
    .busy(busy), .frameDone(frameDone), .txLine(txLine)
  );
endmodule

// File: rtl/dual_tx_chk.sv
module dual_tx_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          baudTick,
  input logic          fifoMode,
  input logic          txLine,
  input logic          spaceIrq,
  input logic          emptyIrq,
  input logic          overflow,
  input logic [CW-1:0] qCount
);
  // R1: the line moves only right after a bit boundary
  a_r1_line_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(baudTick));

  // R8: dropped-write flag is sticky
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R7: drained pulse only in queued mode, only with an idle-high line
  a_r7_empty_mode: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |-> ($past(fifoMode) && txLine));

  // R7: drained pulse lasts one cycle
  a_r7_empty_pulse: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |=> !emptyIrq);

  // R4 / R6: space pulse lasts one cycle
  a_r4_space_pulse: assert property (@(posedge clk) disable iff (!rstN)
    spaceIrq |=> !spaceIrq);

  // R5: queue never holds more than its depth
  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CW'(DEPTH));

  // R3: single mode never holds more than one byte
  a_r3_single_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && $past(!fifoMode)) |-> (qCount <= CW'(1)));
endmodule

bind dual_tx_path dual_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .fifoMode(fifoMode),
  .txLine(txLine), .spaceIrq(spaceIrq), .emptyIrq(emptyIrq),
  .overflow(overflow), .qCount(qCount)
);

// File: tb/dual_tx_path_tb.sv
module dual_tx_path_tb;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoMode = 1'b0, txEnable = 1'b0, msbFirst = 1'b0, sevenBit = 1'b0;
  logic [3:0] trigLevel = 4'd1;
  logic wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic baudTick = 1'b0;
  logic txLine, spaceIrq, emptyIrq, overflow;

  int nChecks = 0, nFail = 0;
  int spaceCnt = 0, emptyCnt = 0;
  logic tickQ = 1'b0;
  logic [7:0] expQ [$];
  logic inFrame = 1'b0;
  int bitPos = 0;
  logic [7:0] got;

  always #4 clk = ~clk;  // 125 MHz

  dual_tx_path u_dut (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .txEnable(txEnable),
    .trigLevel(trigLevel), .msbFirst(msbFirst), .sevenBit(sevenBit),
    .wrValid(wrValid), .wrData(wrData), .baudTick(baudTick),
    .txLine(txLine), .spaceIrq(spaceIrq), .emptyIrq(emptyIrq),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected bit sequence: position i holds the i-th data bit on the line
  function automatic logic [7:0] expSeq(input logic [7:0] d, input logic msb);
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = msb ? d[7-i] : d[i];
    return s;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
      repeat (TICK_DIV - 2) @(negedge clk);
    end
  end

  always @(posedge clk) tickQ <= baudTick;

  // Line monitor and frame decoder, sampled mid-cycle
  logic lastLine = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (spaceIrq) spaceCnt++;
      if (emptyIrq) emptyCnt++;
      if (!tickQ) check(txLine == lastLine, "R1 line moved off tick", txLine, lastLine);
      else begin
        if (!inFrame) begin
          if (txLine == 1'b0) begin inFrame = 1'b1; bitPos = 0; got = 8'h00; end
        end else if (bitPos < (sevenBit ? 7 : 8)) begin
          got[bitPos] = txLine;
          bitPos++;
        end else begin
          logic [7:0] e, m;
          inFrame = 1'b0;
          check(txLine == 1'b1, "R1 stop bit", txLine, 1);
          if (expQ.size() == 0) check(1'b0, "R3/R5/R9 unexpected frame", got, 0);
          else begin
            e = expSeq(expQ.pop_front(), msbFirst);
            m = sevenBit ? 8'h7F : 8'hFF;
            check((got & m) == (e & m), "R2 frame data", got & m, e & m);
          end
        end
      end
    end
    lastLine = txLine;
  end

  task automatic waitTicks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic clearIrqCounts();
    spaceCnt = 0; emptyCnt = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, a;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(txLine == 1'b1, "R10 line idle", txLine, 1);
    check(spaceIrq == 1'b0 && emptyIrq == 1'b0, "R10 irqs low", {spaceIrq, emptyIrq}, 0);
    check(overflow == 1'b0, "R10 overflow low", overflow, 0);
    rstN = 1'b1;
    waitTicks(3);
    check(txLine == 1'b1, "R10 nothing sent after reset", txLine, 1);

    // Single mode, all four frame formats, random data (R2 R3 R4 R7)
    txEnable = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      msbFirst = cfg[0]; sevenBit = cfg[1];
      clearIrqCounts();
      for (int k = 0; k < 4; k++) begin
        d = 8'($urandom);
        if (k == 0) d = sevenBit ? (msbFirst ? 8'h01 : 8'h80) : d;  // ignored bit set
        expQ.push_back(d);
        writeByte(d);
        waitTicks(12);
      end
      check(expQ.size() == 0, "R3 single bytes all sent", expQ.size(), 0);
      check(spaceCnt == 4, "R4 space per load", spaceCnt, 4);
      check(emptyCnt == 0, "R7 no drained pulse in single mode", emptyCnt, 0);
    end

    // Queued mode trigger gating and batch pulses (R5 R6 R7)
    txEnable = 1'b0; msbFirst = 1'b0; sevenBit = 1'b0;
    fifoMode = 1'b1; trigLevel = 4'd4;
    waitTicks(2);
    clearIrqCounts();
    txEnable = 1'b1;
    for (int k = 0; k < 3; k++) begin d = 8'($urandom); expQ.push_back(d); writeByte(d); end
    waitTicks(15);
    check(expQ.size() == 3, "R5 below trigger holds", expQ.size(), 3);
    check(txLine == 1'b1, "R5 line idle below trigger", txLine, 1);
    for (int k = 0; k < 5; k++) begin d = 8'($urandom); expQ.push_back(d); writeByte(d); end
    waitTicks(90);
    check(expQ.size() == 0, "R5 queued bytes sent in order", expQ.size(), 0);
    check(spaceCnt == 2, "R6 space per batch of 4", spaceCnt, 2);
    check(emptyCnt == 1, "R7 one drained pulse", emptyCnt, 1);

    // Full queue: 17th write dropped, trigger 0 means 16 (R5 R6 R7 R8)
    txEnable = 1'b0; trigLevel = 4'd0; msbFirst = 1'b1;
    waitTicks(2);
    clearIrqCounts();
    check(overflow == 1'b0, "R8 no overflow yet", overflow, 0);
    for (int k = 0; k < 17; k++) begin
      d = 8'($urandom);
      if (k < 16) expQ.push_back(d);
      writeByte(d);
    end
    check(overflow == 1'b1, "R8 overflow on full write", overflow, 1);
    txEnable = 1'b1;
    waitTicks(175);
    check(expQ.size() == 0, "R8 dropped byte not sent", expQ.size(), 0);
    check(spaceCnt == 1, "R6 trigger 0 counts 16", spaceCnt, 1);
    check(emptyCnt == 1, "R7 drained after 16", emptyCnt, 1);

    // Disable mid-frame flushes the rest (R9)
    txEnable = 1'b0; trigLevel = 4'd1; msbFirst = 1'b0;
    waitTicks(2);
    clearIrqCounts();
    for (int k = 0; k < 5; k++) begin
      d = 8'($urandom);
      if (k == 0) a = d;
      writeByte(d);
    end
    expQ.push_back(a);
    txEnable = 1'b1;
    while (txLine == 1'b1) @(negedge clk);
    txEnable = 1'b0;
    waitTicks(14);
    check(expQ.size() == 0, "R9 current frame completes", expQ.size(), 0);
    txEnable = 1'b1;
    waitTicks(15);
    check(txLine == 1'b1 && !inFrame, "R9 flushed bytes never sent", txLine, 1);
    check(spaceCnt == 1, "R9 one load before flush", spaceCnt, 1);

    // Single mode holds one byte; a second write is dropped (R3 R8)
    txEnable = 1'b0; fifoMode = 1'b0;
    waitTicks(2);
    a = 8'($urandom); d = ~a;
    writeByte(a);
    writeByte(d);
    expQ.push_back(a);
    txEnable = 1'b1;
    waitTicks(25);
    check(expQ.size() == 0, "R3 held byte sent, second dropped", expQ.size(), 0);
    check(overflow == 1'b1, "R8 overflow stays set", overflow, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule